// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

A single-port synchronous static memory of 9-bit words, meant to serve as the data store of a processor's secondary cache. Every input except output enable is captured on the rising clock edge. A burst is opened by one of two active-low address strobes: one driven by the processor and one driven by the cache controller. Each strobe loads a new base address. An advance strobe then either steps the burst address or holds it to insert a wait state. Write cycles need no external pulse shaping: a write cycle registered at an edge stores its word at that same edge.

Bursts visit four words inside an aligned group. The two low address bits follow an interleaved order: the base's low bits XOR a two-bit step count. After the fourth word the order returns to the base. The two chip selects are sampled only when a strobe loads a base address, and they stay latched until the next strobe. Output enable acts without a clock on the data port. The three-state port is modelled as a data bus plus a drive-enable flag. Read data for a registered access appears during the cycle after the registering edge, which gives flow-through reads. The memory depth is set by the address width parameter.

Top module: `bsram_top`

## Requirements
- R1: Address, data-in, write enable, both strobes, advance and both chip selects take effect only as sampled at a rising clock edge. Changing them between edges does not alter the word presented in the current cycle.
- R2: All 9 bits of a stored word, including bit 8, read back unchanged.
- R3: With `ads_cpu_n` low at an edge, the base address is loaded from `addr`, the step count is cleared, and the cycle is a read regardless of `we_n` and `ads_ctl_n`.
- R4: With `ads_cpu_n` high and `ads_ctl_n` low at an edge, the base address is loaded and the step count is cleared. The cycle is a write when `we_n` is low and a read when it is high.
- R5: Chip selects are sampled only at edges where a strobe is low. The block is enabled when `cs_hi` is 1 and `cs_lo_n` is 0. At edges with both strobes high, the select pins have no effect.
- R6: With both strobes high and `adv_n` low, the step count increments before the access. The accessed address is base[AW-1:2] concatenated with (base[1:0] XOR count). `we_n` picks write (0) or read (1).
- R7: With both strobes high and `adv_n` high, the accessed address is held (wait state). `we_n` still picks read or write.
- R8: After four accessed words (count 0,1,2,3), one more advance returns to the base address.
- R9: `dout_en` is 1 only when the latched selection is enabled, the current cycle is a read, and `oe_n` is 0. Its response to `oe_n` is combinational. When `dout_en` is 1, `dout` equals the word at the accessed address.
- R10: After reset the block is deselected and `dout_en` is 0. A write cycle stores `din` only when the latched selection is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | External base address |
| din | input | 9 | Write data |
| we_n | input | 1 | Write enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| ads_cpu_n | input | 1 | Processor address strobe, active low |
| ads_ctl_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low, unclocked |
| dout | output | 9 | Read data |
| dout_en | output | 1 | Data port drive enable |

## Verification
A wrong step count or base register shows up at the ports within one cycle, as a read of the wrong word in the interleaved order. Because every burst word holds distinct data, an ordering or wrap error becomes a data mismatch on the next read. A stale chip-select latch or read/write flag shows in the same cycle as an unexpected `dout_en`. A write that goes astray surfaces later, when the bench's reference model reads that address back.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int WORD_W = 9;
    localparam int STEP_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        OP_CONT = 2'd0,
        OP_CTL  = 2'd1,
        OP_CPU  = 2'd2
    } start_e;

    // interleaved burst order on the two low address bits
    function automatic step_t burst_low(input step_t base_lo, input step_t cnt);
        return base_lo ^ cnt;
    endfunction
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          ads_cpu_n,
    input  logic          ads_ctl_n,
    input  logic          adv_n,
    output logic [AW-1:0] acc_addr_q,
    output logic          sel_q,
    output logic          wr_q,
    output logic          wr_en_d,
    output logic [AW-1:0] wr_addr_d
);
    typedef struct packed {
        logic [AW-1:0] base;
        step_t         cnt;
        logic          sel;
        logic          wr;
    } state_t;

    state_t st_d, st_q;
    start_e op;

    always_comb begin
        if (!ads_cpu_n)      op = OP_CPU;
        else if (!ads_ctl_n) op = OP_CTL;
        else                 op = OP_CONT;

        st_d = st_q;
        unique case (op)
            OP_CPU: begin
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.sel  = cs_hi & ~cs_lo_n;
                st_d.wr   = 1'b0;
            end
            OP_CTL: begin
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.sel  = cs_hi & ~cs_lo_n;
                st_d.wr   = ~we_n;
            end
            default: begin
                if (!adv_n) st_d.cnt = st_q.cnt + step_t'(1);
                st_d.wr = ~we_n;
            end
        endcase

        wr_en_d   = st_d.sel & st_d.wr;
        wr_addr_d = {st_d.base[AW-1:STEP_W], burst_low(st_d.base[STEP_W-1:0], st_d.cnt)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr_q = {st_q.base[AW-1:STEP_W], burst_low(st_q.base[STEP_W-1:0], st_q.cnt)};
    assign sel_q      = st_q.sel;
    assign wr_q       = st_q.wr;
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [8:0]    din,
    input  logic          we_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          ads_cpu_n,
    input  logic          ads_ctl_n,
    input  logic          adv_n,
    input  logic          oe_n,
    output logic [8:0]    dout,
    output logic          dout_en
);
    logic [AW-1:0] cur_addr;
    logic          cur_sel;
    logic          cur_wr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    word_t         rd_word;

    bsram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n),
        .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
        .acc_addr_q(cur_addr), .sel_q(cur_sel), .wr_q(cur_wr),
        .wr_en_d(wr_en), .wr_addr_d(wr_addr)
    );

    bsram_array #(.AW(AW)) u_array (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(din),
        .raddr(cur_addr), .rdata(rd_word)
    );

    assign dout_en = cur_sel & ~cur_wr & ~oe_n;
    assign dout    = dout_en ? rd_word : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ads_cpu_n,
    input logic          ads_ctl_n,
    input logic          adv_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          dout_en,
    input logic [AW-1:0] cur_addr,
    input logic          cur_sel,
    input logic          cur_wr
);
    a_r3_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_cpu_n |=> !cur_wr);

    a_r4_ctl_strobe_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && !ads_ctl_n && !we_n) |=> cur_wr);

    a_r5_select_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n) |=> $stable(cur_sel));

    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && adv_n) |=> $stable(cur_addr));

    a_r9_drive_rules: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (cur_sel && !cur_wr && !oe_n));

    a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);
endmodule

bind bsram_top bsram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
    .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n), .dout_en(dout_en),
    .cur_addr(cur_addr), .cur_sel(cur_sel), .cur_wr(cur_wr)
);

// File: tb/test_bsram_top.sv
module test_bsram_top;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [8:0]    din = '0;
    logic          we_n = 1'b1, cs_hi = 1'b1, cs_lo_n = 1'b0;
    logic          ads_cpu_n = 1'b1, ads_ctl_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
    logic [8:0]    dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;

    int            ref_mem [int];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_sel = 1'b0;
    logic          m_wr = 1'b0;

    always #5 clk = ~clk;

    bsram_top #(.AW(AW)) i_bsram_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n),
        .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .ads_cpu_n(ads_cpu_n),
        .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input logic [1:0] c);
        return {b[AW-1:2], b[1:0] ^ c};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // present one cycle: inputs held through the edge, then scrambled (R1),
    // then output compared against the model
    task automatic cycle(input logic cpu_n, input logic ctl_n, input logic a_n,
                         input logic w_n, input logic [AW-1:0] a, input logic [8:0] d,
                         input logic s0, input logic s1n, input logic oe);
        string tag;
        logic  exp_en;
        int    exp_d;
        @(negedge clk);
        ads_cpu_n = cpu_n; ads_ctl_n = ctl_n; adv_n = a_n; we_n = w_n;
        addr = a; din = d; cs_hi = s0; cs_lo_n = s1n; oe_n = oe;
        @(posedge clk);
        #1;
        if (!cpu_n) begin
            m_base = a; m_cnt = 2'd0; m_sel = s0 & ~s1n; m_wr = 1'b0; tag = "R3";
        end else if (!ctl_n) begin
            m_base = a; m_cnt = 2'd0; m_sel = s0 & ~s1n; m_wr = ~w_n; tag = "R4";
        end else begin
            if (!a_n) begin m_cnt = m_cnt + 2'd1; tag = "R6"; end
            else tag = "R7";
            m_wr = ~w_n;
        end
        if (m_sel && m_wr) ref_mem[int'(exp_addr(m_base, m_cnt))] = int'(d);
        // R1: scramble sampled inputs; the current access must not move
        addr = AW'($urandom); din = 9'($urandom); cs_hi = ~cs_hi; cs_lo_n = ~cs_lo_n;
        #1;
        exp_en = m_sel && !m_wr && !oe;
        check(dout_en === exp_en, "R9 dout_en", int'(dout_en), int'(exp_en));
        if (exp_en && ref_mem.exists(int'(exp_addr(m_base, m_cnt)))) begin
            exp_d = ref_mem[int'(exp_addr(m_base, m_cnt))];
            check(int'(dout) == exp_d, {tag, "/R1 data"}, int'(dout), exp_d);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state deselected
        check(dout_en === 1'b0, "R10 reset dout_en", int'(dout_en), 0);
        rst_n = 1'b1;

        // fill memory via controller-strobe write bursts (R4, R6)
        for (int b = 0; b < DEPTH; b += 4) begin
            cycle(1, 0, 1, 0, AW'(b), 9'(b * 7 + 3), 1, 0, 0);
            for (int k = 1; k < 4; k++)
                cycle(1, 1, 0, 0, '0, 9'((b ^ k) * 7 + 3), 1, 0, 0);
        end

        // R8: processor burst from base 5 -> 5,4,7,6, then wrap to 5
        cycle(0, 1, 1, 1, 6'd5, '0, 1, 0, 0);
        for (int k = 0; k < 4; k++) cycle(1, 1, 0, 1, '0, '0, 1, 0, 0);
        check(int'(dout) == ref_mem[5], "R8 wrap", int'(dout), ref_mem[5]);

        // R7: wait states hold the word
        cycle(1, 1, 1, 1, '0, '0, 1, 0, 0);
        cycle(1, 1, 1, 1, '0, '0, 1, 0, 0);

        // R3: processor strobe with we_n low still reads, ctl strobe ignored
        cycle(0, 0, 1, 0, 6'd10, 9'h1FF, 1, 0, 0);
        check(dout_en === 1'b1, "R3 read despite we_n", int'(dout_en), 1);

        // R2: ninth bit kept
        cycle(1, 0, 1, 0, 6'd20, 9'h155, 1, 0, 0);
        cycle(1, 0, 1, 1, 6'd20, '0, 1, 0, 0);
        check(dout === 9'h155, "R2 bit8", int'(dout), 'h155);

        // R9: oe_n high blocks drive on a read cycle
        cycle(1, 1, 1, 1, '0, '0, 1, 0, 1);
        check(dout_en === 1'b0, "R9 oe high", int'(dout_en), 0);

        // R5/R10: deselect at strobe; writes dropped, select pins ignored later
        cycle(1, 0, 1, 0, 6'd20, 9'h0AA, 0, 0, 0);
        cycle(1, 1, 1, 1, '0, '0, 1, 0, 0);
        check(dout_en === 1'b0, "R5 latched deselect", int'(dout_en), 0);
        cycle(1, 0, 1, 1, 6'd20, '0, 1, 0, 0);
        check(dout === 9'h155, "R10 no write while deselected", int'(dout), 'h155);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            automatic int r = int'($urandom_range(0, 99));
            cycle(r < 10 ? 1'b0 : 1'b1, (r >= 10 && r < 25) ? 1'b0 : 1'b1,
                  1'($urandom), 1'($urandom), AW'($urandom), 9'($urandom),
                  $urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0,
                  $urandom_range(0, 4) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule